// File: doc/BRIEF.md
# Operand Effective Address Generator

This block sits beside the decode stage of a small 8-bit processor and works out where a load or store operand lives. A 2-bit mode chooses between a constant carried in the program word after the opcode, a full 16-bit data address carried in that same word, or an address formed from one of three 16-bit index registers plus a short unsigned displacement. Besides the address, the block reports whether the extra program word is consumed and whether data memory is touched at all.

The block also contains a small sequencer for 16-bit loads over an 8-bit data path. When it is started, it captures the current effective address as a base. It then reads the low byte at the base and the high byte at base plus one, one byte per cycle. It assembles the two bytes low-byte-first into a word and raises a one-cycle done strobe. The byte memory is assumed to return data in the same cycle as the address it is given.

Top module: `oea_agen`

## Requirements
- R1: With mode code 00 (immediate), `imm_val` equals `next_word`, `eff_addr` is 0, `mem_access` is 0 and `extra_word` is 1.
- R2: With mode code 01 (direct), `eff_addr` equals `next_word`, `imm_val` is 0, `mem_access` is 1 and `extra_word` is 1.
- R3: With mode code 10 (indirect), `idx_sel` picks the base register: 00 gives `reg_x`, 01 gives `reg_y`, and both 10 and 11 give `reg_z`.
- R4: In indirect mode, `eff_addr` is the selected register plus the zero-extended 6-bit `disp`, modulo 2^16. In this mode `mem_access` is 1, `extra_word` is 0 and `imm_val` is 0.
- R5: Mode code 11 (reserved) drives `eff_addr`, `imm_val`, `mem_access` and `extra_word` all to 0.
- R6: A `wide_start` pulse is accepted only while the sequencer is idle and `mem_access` is 1. It captures `eff_addr` as the base, and `wide_busy` is high in the next cycle. A start in any other case leaves `wide_busy` low.
- R7: After an accepted start, `rd_addr` shows the base for one cycle and then base plus one, modulo 2^16, for the following cycle.
- R8: One cycle after the high-byte read, `wide_done` is high for exactly one cycle. At that point `wide_word` holds the byte read at base plus one in bits 15:8 and the byte read at base in bits 7:0. `wide_word` keeps that value until the next completion.
- R9: A `wide_start` that arrives while `wide_busy` is high is ignored. The running load finishes with its original base and yields exactly one done strobe.
- R10: After a synchronous active-low reset, `wide_busy`, `wide_done`, `wide_word` and `rd_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Operand mode code |
| idx_sel | input | 2 | Index register select |
| reg_x | input | 16 | Index register X value |
| reg_y | input | 16 | Index register Y value |
| reg_z | input | 16 | Index register Z value |
| disp | input | 6 | Unsigned displacement |
| next_word | input | 16 | Program word after the opcode |
| wide_start | input | 1 | Begin a 16-bit load at the current address |
| rd_data | input | 8 | Byte returned for `rd_addr` |
| eff_addr | output | 16 | Effective data address |
| imm_val | output | 16 | Immediate operand |
| extra_word | output | 1 | The word after the opcode is consumed |
| mem_access | output | 1 | Data memory is accessed |
| rd_addr | output | 16 | Byte read address of the sequencer |
| wide_busy | output | 1 | 16-bit load in progress |
| wide_done | output | 1 | Assembled word valid, one cycle |
| wide_word | output | 16 | Assembled 16-bit value |

## Verification
The bench targets the index registers near the top of the address space with the largest displacement. A design that failed to wrap, or that sign-extended the displacement, would return the wrong address there. It runs a 16-bit load whose base is 0xFFFF to catch a second-byte address that saturates or carries, and it uses byte patterns in which swapped halves give a visibly different word. It also sends starts while a load is running, and starts in the immediate and reserved modes. A sequencer that restarted, produced a second done strobe, or touched memory for a constant would leave an unmatched or mismatched scoreboard entry.

// File: rtl/oea_pkg.sv
// Shared types for the operand effective address generator.
// Assumes a 2-bit mode code whose values are fixed by the decode stage.
package oea_pkg;
    typedef enum logic [1:0] {
        AM_IMM = 2'b00,
        AM_DIR = 2'b01,
        AM_IND = 2'b10,
        AM_RSV = 2'b11
    } amode_t;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_LO   = 2'd1,
        WS_HI   = 2'd2
    } wstate_t;
endpackage

// File: rtl/oea_index_mux.sv
// Selects one of NUM_IDX index registers.
// Assumes a select code at or beyond NUM_IDX means the last register.
module oea_index_mux #(
    parameter int ADDR_W  = 16,
    parameter int NUM_IDX = 3,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_IDX-1:0][ADDR_W-1:0] regs,
    input  logic [SEL_W-1:0]               sel,
    output logic [ADDR_W-1:0]              idx_val
);
    localparam int LAST = NUM_IDX - 1;

    logic [NUM_IDX-1:0] hit;

    // One hit line per register; the last one also takes out-of-range codes.
    for (genvar g = 0; g < NUM_IDX; g++) begin : g_hit
        if (g == LAST) begin : g_last
            assign hit[g] = (int'(sel) >= g);
        end else begin : g_mid
            assign hit[g] = (int'(sel) == g);
        end
    end

    // OR together the selected register (hit is one-hot).
    always_comb begin
        idx_val = '0;
        for (int i = 0; i < NUM_IDX; i++) begin
            if (hit[i]) idx_val = idx_val | regs[i];
        end
    end
endmodule

// File: rtl/oea_addr_calc.sv
// Forms the effective address, immediate value and mode flags.
// Assumes the displacement is unsigned and addition wraps at ADDR_W bits.
module oea_addr_calc
    import oea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] idx_val,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] next_word,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] imm_val,
    output logic              extra_word,
    output logic              mem_access
);
    localparam int PAD_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] ind_addr;

    // Indirect address: register plus zero-extended displacement, wrapping.
    assign ind_addr = idx_val + {{PAD_W{1'b0}}, disp};

    // Decode the mode into outputs.
    always_comb begin
        eff_addr   = '0;
        imm_val    = '0;
        extra_word = 1'b0;
        mem_access = 1'b0;
        case (amode_t'(mode))
            AM_IMM: begin
                imm_val    = next_word;
                extra_word = 1'b1;
            end
            AM_DIR: begin
                eff_addr   = next_word;
                extra_word = 1'b1;
                mem_access = 1'b1;
            end
            AM_IND: begin
                eff_addr   = ind_addr;
                mem_access = 1'b1;
            end
            default: ;
        endcase
    end

    p_imm_no_mem_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> (!mem_access && extra_word && imm_val == next_word));
    p_dir_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |-> (eff_addr == next_word && mem_access && imm_val == '0));
    p_ind_no_extra_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |-> (!extra_word && mem_access));
    p_rsv_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> (eff_addr == '0 && !mem_access && !extra_word));
endmodule

// File: rtl/oea_word_asm.sv
// Two-cycle 16-bit load sequencer: reads the low byte at the base, then the
// high byte at base+1, and assembles them low byte first.
// Assumes rd_data is valid in the same cycle as rd_addr.
module oea_word_asm
    import oea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                allow,
    input  logic [ADDR_W-1:0]   base_in,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic                busy,
    output logic                done,
    output logic [2*BYTE_W-1:0] word
);
    wstate_t             state;
    logic [ADDR_W-1:0]   base_q;
    logic [BYTE_W-1:0]   lo_q;
    logic [2*BYTE_W-1:0] word_q;
    logic                done_q;

    // Sequence the two byte reads and hold the assembled result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= WS_IDLE;
            base_q <= '0;
            lo_q   <= '0;
            word_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                WS_IDLE: if (start && allow) begin
                    base_q <= base_in;
                    state  <= WS_LO;
                end
                WS_LO: begin
                    lo_q  <= rd_data;
                    state <= WS_HI;
                end
                WS_HI: begin
                    word_q <= {rd_data, lo_q};
                    done_q <= 1'b1;
                    state  <= WS_IDLE;
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    // Present the base, or base+1 during the high-byte read.
    assign rd_addr = (state == WS_HI) ? base_q + 1'b1 : base_q;
    assign busy    = (state != WS_IDLE);
    assign done    = done_q;
    assign word    = word_q;

    p_hi_follows_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_HI) |-> (rd_addr == $past(rd_addr) + 1'b1));
    p_done_after_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_HI) |=> (done && word[BYTE_W-1:0] == $past(lo_q)));
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_base_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != WS_HI) |=> $stable(base_q));
endmodule

// File: rtl/oea_agen.sv
// Top of the operand effective address generator: index select, address
// and flag decode, and the 16-bit little-endian load sequencer.
// Assumes single-cycle byte memory reads on rd_addr/rd_data.
module oea_agen #(
    parameter int ADDR_W  = 16,
    parameter int DISP_W  = 6,
    parameter int BYTE_W  = 8,
    parameter int NUM_IDX = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [1:0]        idx_sel,
    input  logic [ADDR_W-1:0] reg_x,
    input  logic [ADDR_W-1:0] reg_y,
    input  logic [ADDR_W-1:0] reg_z,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] next_word,
    input  logic              wide_start,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] imm_val,
    output logic              extra_word,
    output logic              mem_access,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wide_busy,
    output logic              wide_done,
    output logic [2*BYTE_W-1:0] wide_word
);
    logic [NUM_IDX-1:0][ADDR_W-1:0] regs;
    logic [ADDR_W-1:0]              idx_val;

    assign regs = {reg_z, reg_y, reg_x};

    oea_index_mux #(.ADDR_W(ADDR_W), .NUM_IDX(NUM_IDX), .SEL_W(2)) u_mux (
        .regs    (regs),
        .sel     (idx_sel),
        .idx_val (idx_val)
    );

    oea_addr_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_calc (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .idx_val    (idx_val),
        .disp       (disp),
        .next_word  (next_word),
        .eff_addr   (eff_addr),
        .imm_val    (imm_val),
        .extra_word (extra_word),
        .mem_access (mem_access)
    );

    oea_word_asm #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wide_start),
        .allow   (mem_access),
        .base_in (eff_addr),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .busy    (wide_busy),
        .done    (wide_done),
        .word    (wide_word)
    );

    p_start_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_start && !wide_busy && !mem_access) |=> !wide_busy);
    p_start_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_start && !wide_busy && mem_access) |=> (wide_busy && rd_addr == $past(eff_addr)));
endmodule

// File: tb/tb_oea_agen.sv
`timescale 1ns/1ps
module tb_oea_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [1:0]  idx_sel = 2'b00;
    logic [15:0] reg_x = '0, reg_y = '0, reg_z = '0;
    logic [5:0]  disp = '0;
    logic [15:0] next_word = '0;
    logic        wide_start = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] eff_addr, imm_val, rd_addr, wide_word;
    logic        extra_word, mem_access, wide_busy, wide_done;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];

    always #4 clk = ~clk;

    // Byte memory model: each address returns a pattern unlike its neighbour.
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction
    assign rd_data = mem_byte(rd_addr);

    oea_agen dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .idx_sel(idx_sel),
        .reg_x(reg_x), .reg_y(reg_y), .reg_z(reg_z), .disp(disp),
        .next_word(next_word), .wide_start(wide_start), .rd_data(rd_data),
        .eff_addr(eff_addr), .imm_val(imm_val), .extra_word(extra_word),
        .mem_access(mem_access), .rd_addr(rd_addr), .wide_busy(wide_busy),
        .wide_done(wide_done), .wide_word(wide_word)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected word per done strobe.
    always @(negedge clk) begin
        if (rst_n && wide_done) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected done", 16'h1, 16'h0);
            end else begin
                chk("R8 assembled word", wide_word, exp_q.pop_front());
            end
        end
    end

    // Driver: start a 16-bit load and push the expected little-endian word.
    task automatic wide_load(input logic [15:0] base, input bit poke_busy);
        exp_q.push_back({mem_byte(base + 16'd1), mem_byte(base)});
        wide_start = 1'b1;
        @(negedge clk);
        chk("R6 busy after start", {15'b0, wide_busy}, 16'h1);
        chk("R7 low byte address", rd_addr, base);
        if (poke_busy) begin
            mode = 2'b01; next_word = base ^ 16'h0F0F;
        end else begin
            wide_start = 1'b0;
        end
        @(negedge clk);
        chk("R7 high byte address", rd_addr, base + 16'd1);
        wide_start = 1'b0;
        @(negedge clk);
        chk("R8 done strobe", {15'b0, wide_done}, 16'h1);
        @(negedge clk);
        chk("R8 done one cycle", {15'b0, wide_done}, 16'h0);
        chk("R9 idle after load", {15'b0, wide_busy}, 16'h0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 busy reset", {15'b0, wide_busy}, 16'h0);
        chk("R10 done reset", {15'b0, wide_done}, 16'h0);
        chk("R10 word reset", wide_word, 16'h0);
        chk("R10 rd_addr reset", rd_addr, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 immediate
        mode = 2'b00; next_word = 16'hBEEF; #1;
        chk("R1 imm value", imm_val, 16'hBEEF);
        chk("R1 imm addr", eff_addr, 16'h0);
        chk("R1 imm flags", {14'b0, extra_word, mem_access}, 16'h2);
        // R2 direct
        mode = 2'b01; next_word = 16'h1234; #1;
        chk("R2 direct addr", eff_addr, 16'h1234);
        chk("R2 direct imm", imm_val, 16'h0);
        chk("R2 direct flags", {14'b0, extra_word, mem_access}, 16'h3);
        // R3 / R4 indirect
        mode = 2'b10; reg_x = 16'h1000; reg_y = 16'h2000; reg_z = 16'hFFF0; disp = 6'd5;
        idx_sel = 2'b00; #1; chk("R3 select X", eff_addr, 16'h1005);
        idx_sel = 2'b01; #1; chk("R3 select Y", eff_addr, 16'h2005);
        idx_sel = 2'b10; #1; chk("R3 select Z", eff_addr, 16'hFFF5);
        idx_sel = 2'b11; #1; chk("R3 code 11 gives Z", eff_addr, 16'hFFF5);
        disp = 6'd63; #1; chk("R4 unsigned wrap", eff_addr, 16'h002F);
        chk("R4 indirect flags", {14'b0, extra_word, mem_access}, 16'h1);
        chk("R4 indirect imm", imm_val, 16'h0);
        // R5 reserved
        mode = 2'b11; next_word = 16'h5555; #1;
        chk("R5 reserved addr", eff_addr, 16'h0);
        chk("R5 reserved flags", {14'b0, extra_word, mem_access}, 16'h0);
        chk("R5 reserved imm", imm_val, 16'h0);

        // R6 starts refused in immediate and reserved modes
        @(negedge clk);
        wide_start = 1'b1;
        @(negedge clk);
        chk("R6 reserved start refused", {15'b0, wide_busy}, 16'h0);
        mode = 2'b00;
        @(negedge clk);
        chk("R6 immediate start refused", {15'b0, wide_busy}, 16'h0);
        wide_start = 1'b0;

        // R7 R8 loads: direct, indirect, wrap at top of space
        mode = 2'b01; next_word = 16'h3C21;
        wide_load(16'h3C21, 1'b0);
        mode = 2'b10; idx_sel = 2'b01; disp = 6'd17; #1;
        wide_load(16'h2011, 1'b0);
        mode = 2'b01; next_word = 16'hFFFF;
        wide_load(16'hFFFF, 1'b0);
        chk("R8 word held", wide_word, {mem_byte(16'h0000), mem_byte(16'hFFFF)});
        // R9 start held high while busy, with a new address on the inputs
        mode = 2'b01; next_word = 16'h0480;
        wide_load(16'h0480, 1'b1);

        repeat (3) @(negedge clk);
        chk("R9 scoreboard drained", 16'(exp_q.size()), 16'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule